// File: doc/BRIEF.md
# Multi-Context Pipeline Stage Register

This block sits between two stages of a coarse-grained multithreaded pipeline. It keeps one W-bit stage state, plus a valid bit, for each of N hardware threads. Only one thread is active at a time. While no thread change is under way, the active copy acts as a plain pipeline register.

A thread change works without a flush. The block parks the outgoing thread's state in that thread's backing slot. It then brings the incoming thread's parked state back onto the output after a read latency of 1 to 3 cycles. While the restore is running, the output is marked not valid and both the stall and busy outputs are high.

A separate write port lets a finished long-latency operation drop its result straight into the slot of a parked thread. This write does not disturb the running thread. One set of thread-select and switch controls is shared by every bit slice of the stored state.

The sequencer has two states:
- `ST_RUN` is normal register operation.
- `ST_RESTORE` is the read-latency window.

Its two transitions are:
- ACCEPT: `ST_RUN` to `ST_RESTORE`, taken on a switch request whose target differs from the active thread.
- DONE: `ST_RESTORE` to `ST_RUN`, taken on the last edge of the window, where the restored state is loaded.

Top module: `ctx_stage_reg`

## Requirements
- R1: After reset, `act_tid` is 0, `q` is 0, `q_valid`, `stall` and `busy` are 0, and every thread's slot holds data 0 with its valid bit clear, so restoring any thread then gives `q`=0 and `q_valid`=0.
- R2: In `ST_RUN`, with no switch accepted, a clock edge with `cap_en`=1 loads `d_in`/`d_valid` into `q`/`q_valid`, which appear in the next cycle. With `cap_en`=0 the outputs hold.
- R3: A switch request is accepted when the block is in `ST_RUN` and `sw_tid` differs from `act_tid`. From the cycle after the accepting edge, `act_tid` equals the requested thread (binary encoded). `stall` and `busy` are then high for exactly RD_LAT cycles, with `q_valid`=0 throughout.
- R4: In the first cycle after the window, `q`/`q_valid` equal the incoming thread's stored data and valid bit.
- R5: On an accepted switch, the outgoing thread's current `q`/`q_valid` are stored in its slot, and no other slot changes. This costs no cycles beyond RD_LAT.
- R6: A switch request whose target equals `act_tid` is ignored. No stall follows and capture proceeds as in R2.
- R7: While `busy` is high, switch requests and `cap_en` have no effect on `act_tid`, `q` or the window length.
- R8: A background write (`bg_we`) to a thread other than the active one stores `bg_data` with the valid bit set. In `ST_RUN`, a background write that names the active thread is ignored.
- R9: A background write to the incoming thread on the last edge of the restore window wins. `q`=`bg_data` and `q_valid`=1 follow.
- R10: A background write to the outgoing thread in the cycle after the accepting edge beats the buffered save of that thread's state.
- R11: When a switch is accepted on an edge where `cap_en` is also high, the switch takes priority and that cycle's `d_in` is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable for the active state |
| d_in | input | W | Stage state from the upstream stage |
| d_valid | input | 1 | Valid flag for `d_in` |
| sw_req | input | 1 | Thread switch request |
| sw_tid | input | $clog2(N) | Requested thread |
| bg_we | input | 1 | Background result write enable |
| bg_tid | input | $clog2(N) | Thread whose slot receives the result |
| bg_data | input | W | Background result data |
| q | output | W | Stage state to the downstream stage |
| q_valid | output | 1 | Valid flag for `q` |
| stall | output | 1 | High during the restore window |
| busy | output | 1 | High while new switch requests are refused |
| act_tid | output | $clog2(N) | Active thread |

## Verification
Two functions can fall in the same cycle: a background write and a slot update driven by the switch. The first collision is a background write aimed at the incoming thread on the exact edge its restore completes; the correct result is `bg_data` on `q`. The second is a background write to the outgoing thread one cycle after the switch, when the buffered save lands in the same slot; switching back must show the background value. A long seeded sweep over a four-thread configuration mixes requests, captures and background writes on every cycle against an arithmetic model, so these collisions also arise with every thread pairing.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RESTORE = 1'b1
    } ctx_state_e;
endpackage

// File: rtl/ctx_slice.sv
// One bit of stage state for all threads, driven by shared controls.
module ctx_slice #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sv_we,
    input  logic [IW-1:0] sv_idx,
    input  logic          sv_bit,
    input  logic          bg_we,
    input  logic [IW-1:0] bg_idx,
    input  logic          bg_bit,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_bit
);
    logic [N-1:0] cells;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (bg_we && bg_idx == IW'(i)) begin
                    cells[i] <= bg_bit;
                end else if (sv_we && sv_idx == IW'(i)) begin
                    cells[i] <= sv_bit;
                end
            end
        end
    end

    assign rd_bit = cells[rd_idx];
endmodule

// File: rtl/ctx_bank.sv
// Backing store: W+1 slices sharing thread-select and write controls.
module ctx_bank #(
    parameter int W  = 8,
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sv_we,
    input  logic [IW-1:0] sv_idx,
    input  logic [W:0]    sv_word,
    input  logic          bg_we,
    input  logic [IW-1:0] bg_idx,
    input  logic [W:0]    bg_word,
    input  logic [IW-1:0] rd_idx,
    output logic [W:0]    rd_word
);
    localparam int SLICES = W + 1;

    for (genvar b = 0; b < SLICES; b++) begin : g_slice
        ctx_slice #(.N(N), .IW(IW)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .sv_we  (sv_we),
            .sv_idx (sv_idx),
            .sv_bit (sv_word[b]),
            .bg_we  (bg_we),
            .bg_idx (bg_idx),
            .bg_bit (bg_word[b]),
            .rd_idx (rd_idx),
            .rd_bit (rd_word[b])
        );
    end
endmodule

// File: rtl/ctx_seq.sv
// Switch sequencer: run / restore window of RD_LAT cycles.
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int RD_LAT = 2,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_req,
    input  logic [IW-1:0] sw_tid,
    input  logic [IW-1:0] act_tid,
    output logic          accept,
    output logic          finish,
    output logic          restoring
);
    localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

    ctx_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        accept    = 1'b0;
        finish    = 1'b0;
        restoring = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (sw_req && sw_tid != act_tid) begin
                    accept   = 1'b1;
                    state_nx = ST_RESTORE;
                    cnt_nx   = CW'(RD_LAT - 1);
                end
            end
            ST_RESTORE: begin
                restoring = 1'b1;
                if (cnt == '0) begin
                    finish   = 1'b1;
                    state_nx = ST_RUN;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // R3
    sw_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_RESTORE));

    // R6
    same_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sw_req && sw_tid == act_tid) |=> (state == ST_RUN));
endmodule

// File: rtl/ctx_stage_reg.sv
module ctx_stage_reg #(
    parameter int W      = 8,
    parameter int N      = 4,
    parameter int RD_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [W-1:0]         d_in,
    input  logic                 d_valid,
    input  logic                 sw_req,
    input  logic [$clog2(N)-1:0] sw_tid,
    input  logic                 bg_we,
    input  logic [$clog2(N)-1:0] bg_tid,
    input  logic [W-1:0]         bg_data,
    output logic [W-1:0]         q,
    output logic                 q_valid,
    output logic                 stall,
    output logic                 busy,
    output logic [$clog2(N)-1:0] act_tid
);
    localparam int IW = $clog2(N);
    localparam int LW = $clog2(RD_LAT + 2);

    logic [IW-1:0] act_q;
    logic [W-1:0]  q_r;
    logic          qv_r;
    logic          save_pend;
    logic [IW-1:0] save_idx;
    logic [W:0]    save_word;
    logic          accept, finish, restoring;
    logic          bg_ok;
    logic [W:0]    bank_rd, load_word;

    ctx_seq #(.RD_LAT(RD_LAT), .IW(IW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .sw_tid    (sw_tid),
        .act_tid   (act_q),
        .accept    (accept),
        .finish    (finish),
        .restoring (restoring)
    );

    // In run mode the active thread's slot is not a background target.
    assign bg_ok = bg_we && (restoring || bg_tid != act_q);

    ctx_bank #(.W(W), .N(N), .IW(IW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sv_we   (save_pend),
        .sv_idx  (save_idx),
        .sv_word (save_word),
        .bg_we   (bg_ok),
        .bg_idx  (bg_tid),
        .bg_word ({1'b1, bg_data}),
        .rd_idx  (act_q),
        .rd_word (bank_rd)
    );

    // A result landing on the restoring thread this edge is forwarded.
    assign load_word = (bg_ok && bg_tid == act_q) ? {1'b1, bg_data} : bank_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= '0;
            q_r       <= '0;
            qv_r      <= 1'b0;
            save_pend <= 1'b0;
            save_idx  <= '0;
            save_word <= '0;
        end else begin
            save_pend <= accept;
            if (accept) begin
                save_idx  <= act_q;
                save_word <= {qv_r, q_r};
                act_q     <= sw_tid;
                qv_r      <= 1'b0;
            end else if (finish) begin
                q_r  <= load_word[W-1:0];
                qv_r <= load_word[W];
            end else if (!restoring && cap_en) begin
                q_r  <= d_in;
                qv_r <= d_valid;
            end
        end
    end

    assign q       = q_r;
    assign q_valid = qv_r;
    assign stall   = restoring;
    assign busy    = restoring;
    assign act_tid = act_q;

    // Window-length checker.
    logic [LW-1:0] stall_len;
    always_ff @(posedge clk) begin
        if (!rst_n)     stall_len <= '0;
        else if (stall) stall_len <= stall_len + 1'b1;
        else            stall_len <= '0;
    end

    // R3
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_len < LW'(RD_LAT)));

    // R3
    stall_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !q_valid);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (act_tid == $past(act_tid)));

    // R3
    sw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_req && sw_tid != act_tid) |=> (stall && act_tid == $past(sw_tid)));
endmodule

// File: tb/ctx_stage_reg_tb.sv
`timescale 1ns/100ps
module ctx_stage_reg_tb;
    localparam int W = 8, N = 4, RD_LAT = 2, IW = 2;

    logic clk = 0, rst_n = 0;
    logic cap_en = 0, d_valid = 0, sw_req = 0, bg_we = 0;
    logic [W-1:0] d_in = '0, bg_data = '0;
    logic [IW-1:0] sw_tid = '0, bg_tid = '0;
    logic [W-1:0] q;
    logic q_valid, stall, busy;
    logic [IW-1:0] act_tid;

    int total = 0, bad = 0;

    logic [W-1:0] mb [N];
    logic         mv [N];
    logic [W-1:0] m_q;
    logic         m_qv;
    logic [IW-1:0] m_act;
    int            m_rest;

    always #2.5 clk = ~clk;

    ctx_stage_reg #(.W(W), .N(N), .RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .d_in(d_in), .d_valid(d_valid),
        .sw_req(sw_req), .sw_tid(sw_tid), .bg_we(bg_we), .bg_tid(bg_tid),
        .bg_data(bg_data), .q(q), .q_valid(q_valid), .stall(stall), .busy(busy),
        .act_tid(act_tid)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic model_step();
        if (m_rest > 0) begin
            if (bg_we) begin mb[bg_tid] = bg_data; mv[bg_tid] = 1'b1; end
            if (m_rest == 1) begin m_q = mb[m_act]; m_qv = mv[m_act]; end
            m_rest--;
        end else begin
            if (bg_we && bg_tid != m_act) begin mb[bg_tid] = bg_data; mv[bg_tid] = 1'b1; end
            if (sw_req && sw_tid != m_act) begin
                mb[m_act] = m_q; mv[m_act] = m_qv;
                m_act = sw_tid; m_qv = 1'b0; m_rest = RD_LAT;
            end else if (cap_en) begin
                m_q = d_in; m_qv = d_valid;
            end
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " q"}, int'(q), int'(m_q));
        chk({tag, " q_valid"}, int'(q_valid), int'(m_qv));
        chk({tag, " stall"}, int'(stall), int'(m_rest > 0));
        chk({tag, " busy"}, int'(busy), int'(m_rest > 0));
        chk({tag, " act_tid"}, int'(act_tid), int'(m_act));
    endtask

    task automatic drv(input logic c, input logic [W-1:0] d, input logic dv,
                       input logic s, input int st,
                       input logic b, input int bt, input logic [W-1:0] bd);
        cap_en = c; d_in = d; d_valid = dv; sw_req = s; sw_tid = IW'(st);
        bg_we = b; bg_tid = IW'(bt); bg_data = bd;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            drv(0, '0, 0, 0, 0, 0, 0, '0);
            tick(tag);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog: got=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mb[i] = '0; mv[i] = 1'b0; end
        m_q = '0; m_qv = 1'b0; m_act = '0; m_rest = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 q", int'(q), 0);
        chk("R1 q_valid", int'(q_valid), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 act_tid", int'(act_tid), 0);
        // R1 every other slot empty
        for (int t = 1; t < N; t++) begin
            drv(0, '0, 0, 1, t, 0, 0, '0); tick("R1 sw");
            idle(RD_LAT, "R1 slot");
        end
        drv(0, '0, 0, 1, 0, 0, 0, '0); tick("R1 sw");
        idle(RD_LAT, "R1 slot");
        // R2 capture sweep
        for (int v = 0; v < 32; v++) begin
            drv(v[0], W'(v * 37 + 5), v[1], 0, 0, 0, 0, '0);
            tick("R2 cap");
        end
        // R3 R4 R5 R6 all thread pairs
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                drv(1, W'(16 * a + b + 1), 1, 0, 0, 0, 0, '0); tick("R2 load");
                drv(0, '0, 0, 1, a, 0, 0, '0);
                tick(a == int'(m_act) ? "R6 same" : "R3 sw");
                idle(RD_LAT, "R4 restore");
                drv(1, W'(16 * b + a + 100), b[0], 0, 0, 0, 0, '0); tick("R2 load");
                drv(0, '0, 0, 1, b, 0, 0, '0);
                tick(b == a ? "R6 same" : "R5 save");
                idle(RD_LAT + 1, "R4 restore");
            end
        end
        // R7 requests and capture during busy
        drv(0, '0, 0, 1, (int'(m_act) + 1) % N, 0, 0, '0); tick("R3 sw");
        for (int i = 0; i < RD_LAT; i++) begin
            drv(1, 8'hA5, 1, 1, (int'(m_act) + 2) % N, 0, 0, '0); tick("R7 busy");
        end
        idle(2, "R7 after");
        // R8 background writes to inactive and active threads
        for (int t = 0; t < N; t++) begin
            drv(0, '0, 0, 0, 0, 1, t, W'(8'hC0 + t)); tick("R8 bg");
        end
        for (int t = 0; t < N; t++) begin
            drv(0, '0, 0, 1, t, 0, 0, '0); tick("R8 sw");
            idle(RD_LAT, "R8 check");
        end
        // R9 background write on last restore edge
        drv(0, '0, 0, 1, (int'(m_act) + 1) % N, 0, 0, '0); tick("R9 sw");
        for (int i = 0; i < RD_LAT - 1; i++) begin
            drv(0, '0, 0, 0, 0, 0, 0, '0); tick("R9 wait");
        end
        drv(0, '0, 0, 0, 0, 1, act_tid, 8'h5A); tick("R9 fwd");
        idle(1, "R9 hold");
        // R10 background write to outgoing thread right after switch
        begin
            int old;
            old = int'(m_act);
            drv(1, 8'h33, 1, 0, 0, 0, 0, '0); tick("R2 load");
            drv(0, '0, 0, 1, (old + 1) % N, 0, 0, '0); tick("R10 sw");
            drv(0, '0, 0, 0, 0, 1, old, 8'h99); tick("R10 bg");
            idle(RD_LAT, "R10 wait");
            drv(0, '0, 0, 1, old, 0, 0, '0); tick("R10 back");
            idle(RD_LAT, "R10 check");
        end
        // R11 switch and capture on the same edge
        drv(1, 8'h77, 1, 1, (int'(m_act) + 3) % N, 0, 0, '0); tick("R11 sw");
        idle(RD_LAT + 1, "R11 after");
        // mixed sweep
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom);
            drv(r[0], W'(r >> 8), r[1], (r[4:2] == 3'd0), (r >> 5) % N,
                r[7], (r >> 16) % N, W'(r >> 20));
            tick("R5 mixed");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule